// File: doc/BRIEF.md
# DMA Controller Programming Port

This block is the byte-wide port through which a processor programs a two-port DMA controller. Every byte the processor writes is either a base byte, which selects one of six control groups (or carries a command), or a parameter byte that fills a register named by an earlier base byte. A base byte lists the parameter bytes that will follow through flag bits. The port keeps a short queue of the register identifiers still expected and sends each later byte to the next identifier in that queue until the queue is drained.

Command bytes are decoded into single-cycle strobes for the transfer engine and the interrupt logic. Both of those lie outside this block. They read the programmed registers from this block's outputs and supply the live byte counter, both live port addresses and the status conditions. Reads come from a small sequence buffer. A programmable select mask chooses which of the status byte, the counter bytes and the address bytes are captured. Successive reads then walk through the captured bytes and wrap.

Top module: `dma_prog_port`

## Requirements
- R1: After reset every register output, `dma_en` and `cmd_pulse` are zero, the parameter queue and the read buffer are empty, and `rd_data` shows the live status byte.
- R2: When the queue is empty, a written byte is classified by the first match in this order: (d&0x87)==0x00 group 2; (d&0x87)==0x04 group 1; bit 7 clear group 0; (d&0x83)==0x80 group 3; (d&0x83)==0x81 group 4; (d&0xC7)==0x82 group 5; (d&0x83)==0x83 command. Groups 0 to 5 latch the whole byte on `base_wr0`..`base_wr5`. Any other byte has no effect.
- R3: A group 0 byte queues port A address low (bit 3), port A address high (bit 4), block length low (bit 5) and block length high (bit 6), in that order, taking only the flagged ones.
- R4: Groups 1 and 2 queue the port A or port B timing byte when bit 6 is set. Group 3 queues the mask byte (bit 3) and then the match byte (bit 4), and it loads `dma_en` from its bit 6.
- R5: Group 4 queues port B address low (bit 2), port B address high (bit 3) and interrupt control (bit 4). Writing interrupt control appends the pulse byte (its bit 3) and then the vector byte (its bit 4) to the end of the queue.
- R6: While the queue holds entries, every written byte goes to the register at the head of the queue, even if it would classify as a base byte or command. The queue empties once its last entry is filled.
- R7: A command byte raises exactly one bit of `cmd_pulse` for the one cycle after the write: bit0 0xC3, bit1 0xC7, bit2 0xCB, bit3 0xD3, bit4 0x87, bit5 0x83, bit6 0xB3, bit7 0xAB, bit8 0xAF, bit9 0xA3, bit10 0xB7, bit11 0xBF, bit12 0x8B, bit13 0xA7, bit14 0xBB, bit15 0xCF (load). Any other command byte raises no bit. 0xBB queues one read mask byte.
- R8: 0x87 sets `dma_en`. 0x83 and 0xC3 clear it. 0xC7 clears the port A timing byte and 0xCB clears the port B timing byte.
- R9: Writing the read mask, or command 0xA7 using the stored mask, fills the read buffer with the selected bytes in this order: bit0 status, bit1 counter low, bit2 counter high, bit3 port A low, bit4 port A high, bit5 port B low, bit6 port B high. The values are those present at the loading edge.
- R10: With the read buffer empty, `rd_data` is the live status byte: bit1 = not ready, bit3 = no interrupt pending, bit4 = no match, bit5 = no end of block, and all other bits zero.
- R11: Command 0xBF loads the buffer with the status byte alone.
- R12: Each read strobe with a non-empty buffer advances to the next captured byte and wraps to the first after the last.
- R13: Command 0xC3 empties the read buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Read strobe, advances the read buffer |
| rd_data | output | 8 | Current read byte |
| ready_in | input | 1 | Live ready condition |
| irq_pend_in | input | 1 | Interrupt pending |
| match_hit_in | input | 1 | Search match occurred |
| end_blk_in | input | 1 | End of block reached |
| byte_cnt_in | input | 16 | Live byte counter |
| addr_a_in | input | 16 | Live port A address |
| addr_b_in | input | 16 | Live port B address |
| base_wr0 | output | 8 | Last group 0 base byte |
| base_wr1 | output | 8 | Last group 1 base byte |
| base_wr2 | output | 8 | Last group 2 base byte |
| base_wr3 | output | 8 | Last group 3 base byte |
| base_wr4 | output | 8 | Last group 4 base byte |
| base_wr5 | output | 8 | Last group 5 base byte |
| port_a_addr | output | 16 | Programmed port A start address |
| port_b_addr | output | 16 | Programmed port B start address |
| block_len | output | 16 | Programmed block length |
| timing_a | output | 8 | Port A timing byte |
| timing_b | output | 8 | Port B timing byte |
| mask_byte | output | 8 | Search mask byte |
| match_byte | output | 8 | Search match byte |
| int_ctrl | output | 8 | Interrupt control byte |
| pulse_ctrl | output | 8 | Pulse control byte |
| int_vector | output | 8 | Interrupt vector byte |
| read_mask | output | 8 | Read select mask |
| dma_en | output | 1 | DMA enable flag |
| cmd_pulse | output | 16 | One-cycle command strobes |

## Verification
A corrupt queue entry or pointer does not show up at once. It appears when the next parameter byte lands in the wrong register output, or when a later base byte is taken as a parameter. So every write is followed by a comparison of every register output and of the strobes in the next cycle. A wrong read buffer count or pointer appears on `rd_data` at the first read after the load and at the wrap point. The bench therefore reads past the end of each captured sequence. A misclassified byte appears one cycle after the write, either on the base byte outputs, on `dma_en` or as a missing or extra strobe.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;

  localparam int DW         = 8;
  localparam int NUM_BASE   = 6;
  localparam int NUM_PARAMS = 14;
  localparam int NUM_CMDS   = 16;
  localparam int NUM_RB_SRC = 7;
  localparam int MAX_CAND   = 4;

  typedef enum logic [2:0] {
    K_WR0  = 3'd0,
    K_WR1  = 3'd1,
    K_WR2  = 3'd2,
    K_WR3  = 3'd3,
    K_WR4  = 3'd4,
    K_WR5  = 3'd5,
    K_CMD  = 3'd6,
    K_NONE = 3'd7
  } base_kind_t;

  typedef enum logic [3:0] {
    P_A_LO    = 4'd0,
    P_A_HI    = 4'd1,
    P_LEN_LO  = 4'd2,
    P_LEN_HI  = 4'd3,
    P_TIM_A   = 4'd4,
    P_TIM_B   = 4'd5,
    P_MASK    = 4'd6,
    P_MATCH   = 4'd7,
    P_B_LO    = 4'd8,
    P_B_HI    = 4'd9,
    P_ICTL    = 4'd10,
    P_PULSE   = 4'd11,
    P_VEC     = 4'd12,
    P_RMASK   = 4'd13
  } param_id_t;

  // strobe bit positions on cmd_pulse
  localparam int C_RESET       = 0;
  localparam int C_RST_TIM_A   = 1;
  localparam int C_RST_TIM_B   = 2;
  localparam int C_CONTINUE    = 3;
  localparam int C_ENABLE      = 4;
  localparam int C_DISABLE     = 5;
  localparam int C_FORCE_RDY   = 6;
  localparam int C_INT_ON      = 7;
  localparam int C_INT_OFF     = 8;
  localparam int C_RST_INT_OFF = 9;
  localparam int C_RETI_EN     = 10;
  localparam int C_RD_STATUS   = 11;
  localparam int C_REINIT_STAT = 12;
  localparam int C_INIT_READ   = 13;
  localparam int C_RMASK_NEXT  = 14;
  localparam int C_LOAD        = 15;

  function automatic base_kind_t classify(input logic [DW-1:0] d);
    if      ((d & 8'h87) == 8'h00) return K_WR2;
    else if ((d & 8'h87) == 8'h04) return K_WR1;
    else if (d[7] == 1'b0)         return K_WR0;
    else if ((d & 8'h83) == 8'h80) return K_WR3;
    else if ((d & 8'h83) == 8'h81) return K_WR4;
    else if ((d & 8'hC7) == 8'h82) return K_WR5;
    else if ((d & 8'h83) == 8'h83) return K_CMD;
    else                           return K_NONE;
  endfunction

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_prog_pkg::*;
(
  input  logic                valid,
  input  logic [DW-1:0]       code,
  output logic [NUM_CMDS-1:0] hit
);

  always_comb begin
    hit = '0;
    if (valid) begin
      case (code)
        8'hC3: hit[C_RESET]       = 1'b1;
        8'hC7: hit[C_RST_TIM_A]   = 1'b1;
        8'hCB: hit[C_RST_TIM_B]   = 1'b1;
        8'hD3: hit[C_CONTINUE]    = 1'b1;
        8'h87: hit[C_ENABLE]      = 1'b1;
        8'h83: hit[C_DISABLE]     = 1'b1;
        8'hB3: hit[C_FORCE_RDY]   = 1'b1;
        8'hAB: hit[C_INT_ON]      = 1'b1;
        8'hAF: hit[C_INT_OFF]     = 1'b1;
        8'hA3: hit[C_RST_INT_OFF] = 1'b1;
        8'hB7: hit[C_RETI_EN]     = 1'b1;
        8'hBF: hit[C_RD_STATUS]   = 1'b1;
        8'h8B: hit[C_REINIT_STAT] = 1'b1;
        8'hA7: hit[C_INIT_READ]   = 1'b1;
        8'hBB: hit[C_RMASK_NEXT]  = 1'b1;
        8'hCF: hit[C_LOAD]        = 1'b1;
        default: hit = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_param_queue.sv
module dma_param_queue
  import dma_prog_pkg::*;
#(
  parameter int Q_DEPTH = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  base_kind_t    kind,
  input  logic          rmask_cmd,
  input  logic          par_we,
  input  logic [DW-1:0] din,
  output logic          busy,
  output param_id_t     cur_id
);

  localparam int IW = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam int CW = $clog2(Q_DEPTH + 1);

  param_id_t         q_id_q [Q_DEPTH];
  param_id_t         q_id_d [Q_DEPTH];
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     ptr_q, ptr_d;
  logic [MAX_CAND-1:0] cand_en;
  param_id_t         cand_id [MAX_CAND];
  logic              q_ce;
  logic              unused_din_bits;

  assign unused_din_bits = ^{din[7], din[5], din[1:0]};

  assign busy   = (cnt_q != '0);
  assign cur_id = q_id_q[ptr_q];
  assign q_ce   = base_we | (par_we & busy);

  // candidate follow-on registers selected by the flag bits of a base byte
  always_comb begin
    cand_en = '0;
    for (int i = 0; i < MAX_CAND; i++) cand_id[i] = P_A_LO;
    case (kind)
      K_WR0: begin
        cand_en    = {din[6], din[5], din[4], din[3]};
        cand_id[0] = P_A_LO;
        cand_id[1] = P_A_HI;
        cand_id[2] = P_LEN_LO;
        cand_id[3] = P_LEN_HI;
      end
      K_WR1: begin
        cand_en[0] = din[6];
        cand_id[0] = P_TIM_A;
      end
      K_WR2: begin
        cand_en[0] = din[6];
        cand_id[0] = P_TIM_B;
      end
      K_WR3: begin
        cand_en[1:0] = {din[4], din[3]};
        cand_id[0]   = P_MASK;
        cand_id[1]   = P_MATCH;
      end
      K_WR4: begin
        cand_en[2:0] = {din[4], din[3], din[2]};
        cand_id[0]   = P_B_LO;
        cand_id[1]   = P_B_HI;
        cand_id[2]   = P_ICTL;
      end
      K_CMD: begin
        cand_en[0] = rmask_cmd;
        cand_id[0] = P_RMASK;
      end
      default: cand_en = '0;
    endcase
  end

  always_comb begin
    int k;
    q_id_d = q_id_q;
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    k      = 0;
    if (base_we) begin
      for (int i = 0; i < MAX_CAND; i++) begin
        if (cand_en[i] && (k < Q_DEPTH)) begin
          q_id_d[k] = cand_id[i];
          k++;
        end
      end
      cnt_d = CW'(k);
      ptr_d = '0;
    end else if (par_we && busy) begin
      k = int'(cnt_q);
      if (cur_id == P_ICTL) begin
        if (din[3] && (k < Q_DEPTH)) begin
          q_id_d[k] = P_PULSE;
          k++;
        end
        if (din[4] && (k < Q_DEPTH)) begin
          q_id_d[k] = P_VEC;
          k++;
        end
      end
      if ((int'(ptr_q) + 1) >= k) begin
        cnt_d = '0;
        ptr_d = '0;
      end else begin
        cnt_d = CW'(k);
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < Q_DEPTH; i++) q_id_q[i] <= P_A_LO;
    end else if (q_ce) begin
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      q_id_q <= q_id_d;
    end
  end

  // R6
  q_ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(ptr_q) < int'(cnt_q)));

  // R6
  q_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_we && busy && (int'(ptr_q) + 1 == int'(cnt_q)) && (cur_id != P_ICTL)) |=> !busy);

endmodule

// File: rtl/dma_readback.sv
module dma_readback
  import dma_prog_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DW-1:0]         status_live,
  input  logic [15:0]           cnt_in,
  input  logic [15:0]           a_in,
  input  logic [15:0]           b_in,
  input  logic                  clr,
  input  logic                  ld_status,
  input  logic                  ld_mask,
  input  logic [NUM_RB_SRC-1:0] mask,
  input  logic                  rd_en,
  output logic [DW-1:0]         rd_data
);

  localparam int IW = $clog2(NUM_RB_SRC);
  localparam int CW = $clog2(NUM_RB_SRC + 1);

  logic [DW-1:0] src    [NUM_RB_SRC];
  logic [DW-1:0] buf_q  [NUM_RB_SRC];
  logic [DW-1:0] buf_d  [NUM_RB_SRC];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic          rb_ce;

  assign src[0] = status_live;
  assign src[1] = cnt_in[7:0];
  assign src[2] = cnt_in[15:8];
  assign src[3] = a_in[7:0];
  assign src[4] = a_in[15:8];
  assign src[5] = b_in[7:0];
  assign src[6] = b_in[15:8];

  assign rb_ce   = clr | ld_status | ld_mask | (rd_en & (cnt_q != '0));
  assign rd_data = (cnt_q == '0) ? status_live : buf_q[ptr_q];

  always_comb begin
    int k;
    buf_d = buf_q;
    cnt_d = cnt_q;
    ptr_d = ptr_q;
    k     = 0;
    if (clr) begin
      cnt_d = '0;
      ptr_d = '0;
    end else if (ld_status) begin
      buf_d[0] = status_live;
      cnt_d    = CW'(1);
      ptr_d    = '0;
    end else if (ld_mask) begin
      for (int i = 0; i < NUM_RB_SRC; i++) begin
        if (mask[i]) begin
          buf_d[k] = src[i];
          k++;
        end
      end
      cnt_d = CW'(k);
      ptr_d = '0;
    end else if (rd_en && (cnt_q != '0)) begin
      if ((int'(ptr_q) + 1) >= int'(cnt_q)) ptr_d = '0;
      else                                  ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ptr_q <= '0;
      for (int i = 0; i < NUM_RB_SRC; i++) buf_q[i] <= '0;
    end else if (rb_ce) begin
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
      buf_q <= buf_d;
    end
  end

  // R12
  rb_ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (int'(ptr_q) < int'(cnt_q)));

  // R11
  rb_status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_status && !clr) |=> (rd_data == $past(status_live)));

endmodule

// File: rtl/dma_prog_port.sv
module dma_prog_port
  import dma_prog_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic                rd_en,
  output logic [7:0]          rd_data,
  input  logic                ready_in,
  input  logic                irq_pend_in,
  input  logic                match_hit_in,
  input  logic                end_blk_in,
  input  logic [15:0]         byte_cnt_in,
  input  logic [15:0]         addr_a_in,
  input  logic [15:0]         addr_b_in,
  output logic [7:0]          base_wr0,
  output logic [7:0]          base_wr1,
  output logic [7:0]          base_wr2,
  output logic [7:0]          base_wr3,
  output logic [7:0]          base_wr4,
  output logic [7:0]          base_wr5,
  output logic [15:0]         port_a_addr,
  output logic [15:0]         port_b_addr,
  output logic [15:0]         block_len,
  output logic [7:0]          timing_a,
  output logic [7:0]          timing_b,
  output logic [7:0]          mask_byte,
  output logic [7:0]          match_byte,
  output logic [7:0]          int_ctrl,
  output logic [7:0]          pulse_ctrl,
  output logic [7:0]          int_vector,
  output logic [7:0]          read_mask,
  output logic                dma_en,
  output logic [NUM_CMDS-1:0] cmd_pulse
);

  base_kind_t          kind;
  logic                busy;
  param_id_t           cur_id;
  logic                base_we, par_we, cmd_valid;
  logic [NUM_CMDS-1:0] cmd_hit;
  logic [DW-1:0]       preg_q [NUM_PARAMS];
  logic [DW-1:0]       preg_d [NUM_PARAMS];
  logic [DW-1:0]       base_q [NUM_BASE];
  logic [DW-1:0]       base_d [NUM_BASE];
  logic                en_q, en_d;
  logic [NUM_CMDS-1:0] cmdp_q;
  logic [DW-1:0]       status_live;
  logic                rmask_we, rb_ld_mask;
  logic [NUM_RB_SRC-1:0] rb_mask;
  logic                unused_mask_msb;

  assign kind      = classify(wr_data);
  assign base_we   = wr_en & ~busy;
  assign par_we    = wr_en & busy;
  assign cmd_valid = base_we & (kind == K_CMD);

  assign status_live = {2'b00, ~end_blk_in, ~match_hit_in, ~irq_pend_in,
                        1'b0, ~ready_in, 1'b0};

  dma_cmd_decode u_cmd_decode (
    .valid (cmd_valid),
    .code  (wr_data),
    .hit   (cmd_hit)
  );

  dma_param_queue #(
    .Q_DEPTH (6)
  ) u_param_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_we   (base_we),
    .kind      (kind),
    .rmask_cmd (cmd_hit[C_RMASK_NEXT]),
    .par_we    (par_we),
    .din       (wr_data),
    .busy      (busy),
    .cur_id    (cur_id)
  );

  // register file next state
  always_comb begin
    preg_d = preg_q;
    base_d = base_q;
    en_d   = en_q;
    if (par_we) preg_d[cur_id] = wr_data;
    if (cmd_hit[C_RST_TIM_A]) preg_d[P_TIM_A] = '0;
    if (cmd_hit[C_RST_TIM_B]) preg_d[P_TIM_B] = '0;
    if (base_we && (kind <= K_WR5)) base_d[int'(kind)] = wr_data;
    if (base_we && (kind == K_WR3)) en_d = wr_data[6];
    if (cmd_hit[C_ENABLE]) en_d = 1'b1;
    if (cmd_hit[C_DISABLE] || cmd_hit[C_RESET]) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PARAMS; i++) preg_q[i] <= '0;
      for (int i = 0; i < NUM_BASE; i++)   base_q[i] <= '0;
      en_q <= 1'b0;
    end else if (wr_en) begin
      preg_q <= preg_d;
      base_q <= base_d;
      en_q   <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmdp_q <= '0;
    else        cmdp_q <= cmd_hit;
  end

  // read buffer loading
  assign rmask_we        = par_we & (cur_id == P_RMASK);
  assign rb_ld_mask      = rmask_we | cmd_hit[C_INIT_READ];
  assign rb_mask         = rmask_we ? wr_data[NUM_RB_SRC-1:0] : preg_q[P_RMASK][NUM_RB_SRC-1:0];
  assign unused_mask_msb = preg_q[P_RMASK][7];

  dma_readback u_readback (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_live (status_live),
    .cnt_in      (byte_cnt_in),
    .a_in        (addr_a_in),
    .b_in        (addr_b_in),
    .clr         (cmd_hit[C_RESET]),
    .ld_status   (cmd_hit[C_RD_STATUS]),
    .ld_mask     (rb_ld_mask),
    .mask        (rb_mask),
    .rd_en       (rd_en),
    .rd_data     (rd_data)
  );

  // outputs
  assign base_wr0    = base_q[0];
  assign base_wr1    = base_q[1];
  assign base_wr2    = base_q[2];
  assign base_wr3    = base_q[3];
  assign base_wr4    = base_q[4];
  assign base_wr5    = base_q[5];
  assign port_a_addr = {preg_q[P_A_HI], preg_q[P_A_LO]};
  assign port_b_addr = {preg_q[P_B_HI], preg_q[P_B_LO]};
  assign block_len   = {preg_q[P_LEN_HI], preg_q[P_LEN_LO]};
  assign timing_a    = preg_q[P_TIM_A];
  assign timing_b    = preg_q[P_TIM_B];
  assign mask_byte   = preg_q[P_MASK];
  assign match_byte  = preg_q[P_MATCH];
  assign int_ctrl    = preg_q[P_ICTL];
  assign pulse_ctrl  = preg_q[P_PULSE];
  assign int_vector  = preg_q[P_VEC];
  assign read_mask   = preg_q[P_RMASK];
  assign dma_en      = en_q;
  assign cmd_pulse   = cmdp_q;

  // R7
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse));

  // R8
  dma_en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_en) |-> $past(wr_en));

  // R6
  param_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> (cmd_pulse == '0));

  // R4
  wr3_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && (kind == K_WR3)) |=> (dma_en == $past(wr_data[6])));

endmodule

// File: tb/dma_prog_port_bench.sv
module dma_prog_port_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, wr_en, rd_en;
  logic [7:0]  wr_data, rd_data;
  logic        ready_in, irq_pend_in, match_hit_in, end_blk_in;
  logic [15:0] byte_cnt_in, addr_a_in, addr_b_in;
  logic [7:0]  base_wr0, base_wr1, base_wr2, base_wr3, base_wr4, base_wr5;
  logic [15:0] port_a_addr, port_b_addr, block_len;
  logic [7:0]  timing_a, timing_b, mask_byte, match_byte;
  logic [7:0]  int_ctrl, pulse_ctrl, int_vector, read_mask;
  logic        dma_en;
  logic [15:0] cmd_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_p [14];
  logic [7:0]  m_b [6];
  logic        m_en;
  logic [15:0] m_cmd;
  int          mq [8];
  int          mqn, mqp;
  logic [7:0]  mrb [8];
  int          mrn, mrp;

  dma_prog_port u_dma_prog_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data),
    .ready_in(ready_in), .irq_pend_in(irq_pend_in),
    .match_hit_in(match_hit_in), .end_blk_in(end_blk_in),
    .byte_cnt_in(byte_cnt_in), .addr_a_in(addr_a_in), .addr_b_in(addr_b_in),
    .base_wr0(base_wr0), .base_wr1(base_wr1), .base_wr2(base_wr2),
    .base_wr3(base_wr3), .base_wr4(base_wr4), .base_wr5(base_wr5),
    .port_a_addr(port_a_addr), .port_b_addr(port_b_addr), .block_len(block_len),
    .timing_a(timing_a), .timing_b(timing_b), .mask_byte(mask_byte),
    .match_byte(match_byte), .int_ctrl(int_ctrl), .pulse_ctrl(pulse_ctrl),
    .int_vector(int_vector), .read_mask(read_mask), .dma_en(dma_en),
    .cmd_pulse(cmd_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] st();
    return {2'b00, ~end_blk_in, ~match_hit_in, ~irq_pend_in, 1'b0, ~ready_in, 1'b0};
  endfunction

  // R2 priority order
  function automatic int kind_of(input logic [7:0] d);
    if ((d & 8'h87) == 8'h00) return 2;
    if ((d & 8'h87) == 8'h04) return 1;
    if (!d[7]) return 0;
    if ((d & 8'h83) == 8'h80) return 3;
    if ((d & 8'h83) == 8'h81) return 4;
    if ((d & 8'hC7) == 8'h82) return 5;
    if ((d & 8'h83) == 8'h83) return 6;
    return 7;
  endfunction

  function automatic logic [7:0] get_p(input int id);
    case (id)
      0: return port_a_addr[7:0];
      1: return port_a_addr[15:8];
      2: return block_len[7:0];
      3: return block_len[15:8];
      4: return timing_a;
      5: return timing_b;
      6: return mask_byte;
      7: return match_byte;
      8: return port_b_addr[7:0];
      9: return port_b_addr[15:8];
      10: return int_ctrl;
      11: return pulse_ctrl;
      12: return int_vector;
      default: return read_mask;
    endcase
  endfunction

  function automatic logic [7:0] get_b(input int i);
    case (i)
      0: return base_wr0;
      1: return base_wr1;
      2: return base_wr2;
      3: return base_wr3;
      4: return base_wr4;
      default: return base_wr5;
    endcase
  endfunction

  task automatic push(input int id);
    mq[mqn] = id;
    mqn++;
  endtask

  task automatic rebuild(input logic [7:0] mask);
    logic [7:0] s [7];
    s[0] = st();
    s[1] = byte_cnt_in[7:0];  s[2] = byte_cnt_in[15:8];
    s[3] = addr_a_in[7:0];    s[4] = addr_a_in[15:8];
    s[5] = addr_b_in[7:0];    s[6] = addr_b_in[15:8];
    mrn = 0; mrp = 0;
    for (int i = 0; i < 7; i++) if (mask[i]) begin mrb[mrn] = s[i]; mrn++; end
  endtask

  task automatic model_write(input logic [7:0] d);
    int k, id;
    m_cmd = '0;
    if (mqn > 0) begin
      id = mq[mqp];
      m_p[id] = d;
      if (id == 10) begin
        if (d[3]) push(11);
        if (d[4]) push(12);
      end
      if (id == 13) rebuild(d);
      mqp++;
      if (mqp >= mqn) begin mqn = 0; mqp = 0; end
    end else begin
      k = kind_of(d);
      if (k <= 5) m_b[k] = d;
      case (k)
        0: begin if (d[3]) push(0); if (d[4]) push(1); if (d[5]) push(2); if (d[6]) push(3); end
        1: if (d[6]) push(4);
        2: if (d[6]) push(5);
        3: begin m_en = d[6]; if (d[3]) push(6); if (d[4]) push(7); end
        4: begin if (d[2]) push(8); if (d[3]) push(9); if (d[4]) push(10); end
        6: case (d)
             8'hC3: begin m_cmd[0] = 1; m_en = 0; mrn = 0; mrp = 0; end
             8'hC7: begin m_cmd[1] = 1; m_p[4] = 0; end
             8'hCB: begin m_cmd[2] = 1; m_p[5] = 0; end
             8'hD3: m_cmd[3] = 1;
             8'h87: begin m_cmd[4] = 1; m_en = 1; end
             8'h83: begin m_cmd[5] = 1; m_en = 0; end
             8'hB3: m_cmd[6] = 1;
             8'hAB: m_cmd[7] = 1;
             8'hAF: m_cmd[8] = 1;
             8'hA3: m_cmd[9] = 1;
             8'hB7: m_cmd[10] = 1;
             8'hBF: begin m_cmd[11] = 1; mrb[0] = st(); mrn = 1; mrp = 0; end
             8'h8B: m_cmd[12] = 1;
             8'hA7: begin m_cmd[13] = 1; rebuild(m_p[13]); end
             8'hBB: begin m_cmd[14] = 1; push(13); end
             8'hCF: m_cmd[15] = 1;
             default: ;
           endcase
        default: ;
      endcase
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 14; i++) chk(tag, get_p(i), m_p[i]);
    for (int i = 0; i < 6; i++) chk(tag, get_b(i), m_b[i]);
    chk(tag, dma_en, m_en);
    chk(tag, cmd_pulse, m_cmd);
  endtask

  task automatic do_write(input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    model_write(d);
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  task automatic do_read(input string tag);
    logic [7:0] e;
    @(negedge clk);
    rd_en = 1'b1;
    e = (mrn == 0) ? st() : mrb[mrp];
    chk(tag, rd_data, e);
    if (mrn != 0) begin mrp++; if (mrp >= mrn) mrp = 0; end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_live(input logic r, input logic i, input logic m, input logic e,
                          input logic [15:0] c, input logic [15:0] a, input logic [15:0] b);
    ready_in = r; irq_pend_in = i; match_hit_in = m; end_blk_in = e;
    byte_cnt_in = c; addr_a_in = a; addr_b_in = b;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] cmds [17];
    void'($urandom(32'd20240611));
    cmds = '{8'hC3, 8'hC7, 8'hCB, 8'hD3, 8'h87, 8'h83, 8'hB3, 8'hAB, 8'hAF,
             8'hA3, 8'hB7, 8'hBF, 8'h8B, 8'hA7, 8'hBB, 8'hCF, 8'hFB};
    for (int i = 0; i < 14; i++) m_p[i] = '0;
    for (int i = 0; i < 6; i++) m_b[i] = '0;
    m_en = 0; m_cmd = '0; mqn = 0; mqp = 0; mrn = 0; mrp = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    set_live(1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1");
    chk("R1 status", rd_data, 8'h38 & ~8'h20);

    // R10 live status bits
    set_live(1'b0, 1'b1, 1'b1, 1'b0, 16'h1234, 16'h5678, 16'h9ABC);
    @(negedge clk);
    chk("R10 status", rd_data, 8'h22);
    set_live(1'b1, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h5678, 16'h9ABC);
    @(negedge clk);
    chk("R10 status", rd_data, 8'h38);

    // R3 group 0 full sequence
    do_write(8'h79, "R3");
    do_write(8'h12, "R3"); do_write(8'h34, "R3");
    do_write(8'h56, "R3"); do_write(8'h78, "R3");
    chk("R3 port A", port_a_addr, 16'h3412);
    chk("R3 length", block_len, 16'h7856);
    do_write(8'h21, "R3");
    do_write(8'hAA, "R3");
    chk("R3 len low only", block_len, 16'h78AA);

    // R2 / R4 groups 1 and 2, unclassified byte
    do_write(8'h44, "R4"); do_write(8'h5A, "R4");
    chk("R4 timing A", timing_a, 8'h5A);
    do_write(8'h40, "R2"); do_write(8'hA5, "R2");
    chk("R2 timing B", timing_b, 8'hA5);
    do_write(8'hC2, "R2");
    chk("R2 ignored", base_wr5, 8'h00);
    do_write(8'h82, "R2");
    chk("R2 group5", base_wr5, 8'h82);

    // R4 group 3 with enable
    do_write(8'hD8, "R4"); do_write(8'h0F, "R4"); do_write(8'h0A, "R4");
    chk("R4 mask", mask_byte, 8'h0F);
    chk("R4 match", match_byte, 8'h0A);
    chk("R4 enable", dma_en, 1'b1);

    // R5 group 4 with appended pulse and vector
    do_write(8'h9D, "R5"); do_write(8'hEF, "R5"); do_write(8'hBE, "R5");
    do_write(8'h18, "R5"); do_write(8'h11, "R5"); do_write(8'h22, "R5");
    chk("R5 port B", port_b_addr, 16'hBEEF);
    chk("R5 pulse", pulse_ctrl, 8'h11);
    chk("R5 vector", int_vector, 8'h22);

    // R6 parameter byte that looks like a command
    do_write(8'h09, "R6"); do_write(8'hC3, "R6");
    chk("R6 A low", port_a_addr[7:0], 8'hC3);
    chk("R6 enable kept", dma_en, 1'b1);

    // R7 / R8 each command
    for (int i = 0; i < 17; i++) begin
      do_write(cmds[i], "R7");
      if (cmds[i] == 8'hBB) do_write(8'h01, "R7");
    end
    do_write(8'h87, "R8");
    chk("R8 enable", dma_en, 1'b1);
    do_write(8'h83, "R8");
    chk("R8 disable", dma_en, 1'b0);
    do_write(8'h44, "R8"); do_write(8'h77, "R8");
    do_write(8'hC7, "R8");
    chk("R8 timing A cleared", timing_a, 8'h00);

    // R9 / R12 mask-selected sequence and wrap
    set_live(1'b0, 1'b1, 1'b0, 1'b1, 16'hA1B2, 16'hC3D4, 16'hE5F6);
    do_write(8'hBB, "R9"); do_write(8'h2A, "R9");
    set_live(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000);
    do_read("R9"); do_read("R9"); do_read("R9");
    do_read("R12"); do_read("R12");
    do_write(8'hA7, "R9");
    do_read("R9"); do_read("R9");

    // R11 status only, then R13 clear
    set_live(1'b0, 1'b0, 1'b1, 1'b0, 16'h0101, 16'h0202, 16'h0303);
    do_write(8'hBF, "R11");
    set_live(1'b1, 1'b1, 1'b0, 1'b1, 16'h0101, 16'h0202, 16'h0303);
    do_read("R11"); do_read("R11");
    do_write(8'hC3, "R13");
    do_read("R13"); do_read("R10");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = int'($urandom_range(0, 7));
      set_live(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               16'($urandom), 16'($urandom), 16'($urandom));
      if (sel < 2) do_read("R12");
      else if (sel < 4) do_write(cmds[$urandom_range(0, 16)], "R7");
      else do_write(8'($urandom), "R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule